// File: doc/BRIEF.md
# Two-Way Latching Bus Transceiver

This block passes a word between an A bus and a B bus in either direction. Each direction has its own output enable, latch enable, clock enable and direction clock. Each direction works in one of three ways:

- **Pass-through:** when its latch enable is high, input data flows straight to the opposite bus.
- **Capture:** with latch enable low and clock enable active, a rising edge of the direction clock stores the input word.
- **Hold:** otherwise the direction keeps the stored word.

Both buses are tri-state. A direction drives only while its output enable is low.

Everything runs on one fast system clock. The two direction clocks are asynchronous to it. Each one passes through a two-flop synchronizer, and its rising edges are found by comparing successive samples. While latch enable is high, the storage word also follows the input on every system clock. Dropping latch enable therefore keeps the last word that passed through. A synchronous active-high reset clears both stored words and both synchronizers.

Top module: `bidir_xcvr`

## Requirements
- R1: With a direction's latch enable high, its output equals its input bus word in the same cycle, whatever its clock and clock-enable levels.
- R2: With latch enable low and clock enable low, a rising direction clock stores the input word. The stored word shows on the output three system-clock edges after the direction clock rises.
- R3: With latch enable low and the direction clock steady (high or low), or on a falling clock edge, the output keeps its stored word while the input changes.
- R4: With clock enable high and latch enable low, rising direction clock edges are ignored and the stored word is kept.
- R5: With output enable high, a direction releases its bus, so an outside driver's value is seen on that bus. With output enable low, the direction drives its output word.
- R6: The B-to-A direction behaves like A-to-B using its own four controls. Activity in one direction does not change the other direction's stored word.
- R7: When latch enable falls, the word last passed through stays stored and keeps showing on the output.
- R8: Reset (active high, synchronous) clears both stored words to zero.
- R9: All W bits follow the same controls. Patterns of all ones, all zeros and alternating bits pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ab_oe_n | input | 1 | A-to-B output enable, low drives B bus |
| ab_le | input | 1 | A-to-B latch enable, high is pass-through |
| ab_ce_n | input | 1 | A-to-B clock enable, low allows capture |
| ab_cp | input | 1 | A-to-B direction clock (asynchronous) |
| ba_oe_n | input | 1 | B-to-A output enable, low drives A bus |
| ba_le | input | 1 | B-to-A latch enable |
| ba_ce_n | input | 1 | B-to-A clock enable |
| ba_cp | input | 1 | B-to-A direction clock (asynchronous) |
| a_bus | inout | W | A-side bus |
| b_bus | inout | W | B-side bus |

## Verification
The bench looks for the ways a direction's storage can go wrong:

- **Clock held high while data moves:** a design that captured on level would follow the input.
- **Falling clock edge:** a design that captured on any edge would take the new word.
- **Clock enable inactive during a rising edge:** a design that ignored the enable would overwrite the stored word.
- **Latch enable falling:** a design that stored only on clock edges would show a stale word instead of the last word that passed through.

Tri-state release is checked by driving the bus from outside while the direction is disabled; a design that kept driving would corrupt that value. Independence is checked by capturing in the B-to-A direction and then confirming that the A-to-B stored word is unchanged.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_LOAD = 2'd1,
    MODE_KEEP = 2'd2
  } lane_mode_e;

  function automatic lane_mode_e pick_mode(input logic le, input logic ce_n,
                                           input logic rise);
    if (le)
      return MODE_PASS;
    else if (!ce_n && rise)
      return MODE_LOAD;
    else
      return MODE_KEEP;
  endfunction

endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cp_async,
  output logic cp_rise
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] samp_q;

  always_ff @(posedge clk) begin
    if (rst)
      samp_q <= '0;
    else
      samp_q <= {samp_q[DEPTH-2:0], cp_async};
  end

  assign cp_rise = samp_q[SYNC_STAGES-1] & ~samp_q[SYNC_STAGES];
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         ce_n,
  input  logic         cp_rise,
  input  logic         oe_n,
  output logic [W-1:0] dout,
  output logic         drive_en,
  output logic [W-1:0] store_q
);
  lane_mode_e mode;

  assign mode = pick_mode(le, ce_n, cp_rise);

  always_ff @(posedge clk) begin
    if (rst)
      store_q <= '0;
    else begin
      case (mode)
        MODE_PASS: store_q <= din;
        MODE_LOAD: store_q <= din;
        default:   store_q <= store_q;
      endcase
    end
  end

  assign dout     = le ? din : store_q;
  assign drive_en = ~oe_n;
endmodule

// File: rtl/bidir_xcvr.sv
module bidir_xcvr #(
  parameter int W           = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_ce_n,
  input  logic         ab_cp,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_ce_n,
  input  logic         ba_cp,
  inout  wire  [W-1:0] a_bus,
  inout  wire  [W-1:0] b_bus
);
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] ab_dout, ba_dout;
  logic [W-1:0] ab_store, ba_store;
  logic         ab_rise, ba_rise;
  logic         ab_drive, ba_drive;

  assign a_in = a_bus;
  assign b_in = b_bus;

  xcvr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) ab_edge_i (
    .clk(clk), .rst(rst), .cp_async(ab_cp), .cp_rise(ab_rise)
  );

  xcvr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) ba_edge_i (
    .clk(clk), .rst(rst), .cp_async(ba_cp), .cp_rise(ba_rise)
  );

  xcvr_lane #(.W(W)) ab_lane_i (
    .clk(clk), .rst(rst), .din(a_in), .le(ab_le), .ce_n(ab_ce_n),
    .cp_rise(ab_rise), .oe_n(ab_oe_n), .dout(ab_dout),
    .drive_en(ab_drive), .store_q(ab_store)
  );

  xcvr_lane #(.W(W)) ba_lane_i (
    .clk(clk), .rst(rst), .din(b_in), .le(ba_le), .ce_n(ba_ce_n),
    .cp_rise(ba_rise), .oe_n(ba_oe_n), .dout(ba_dout),
    .drive_en(ba_drive), .store_q(ba_store)
  );

  assign b_bus = ab_drive ? ab_dout : {W{1'bz}};
  assign a_bus = ba_drive ? ba_dout : {W{1'bz}};
endmodule

// File: rtl/bidir_xcvr_chk.sv
module bidir_xcvr_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic         ab_le,
  input logic         ab_ce_n,
  input logic         ba_le,
  input logic         ba_ce_n,
  input logic         ab_rise,
  input logic         ba_rise,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] ab_store,
  input logic [W-1:0] ba_store
);
  // R2
  ab_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && !ab_ce_n && ab_rise) |=> (ab_store == $past(a_in)));

  // R6
  ba_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && !ba_ce_n && ba_rise) |=> (ba_store == $past(b_in)));

  // R3
  ab_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && !ab_rise) |=> $stable(ab_store));

  // R4
  ab_ce_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && ab_ce_n) |=> $stable(ab_store));

  // R6
  ba_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && (ba_ce_n || !ba_rise)) |=> $stable(ba_store));

  // R7
  ab_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ab_le |=> (ab_store == $past(a_in)));

  // R2
  ab_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ab_rise |=> !ab_rise);

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> ((ab_store == '0) && (ba_store == '0)));
endmodule

bind bidir_xcvr bidir_xcvr_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .ab_le(ab_le), .ab_ce_n(ab_ce_n),
  .ba_le(ba_le), .ba_ce_n(ba_ce_n), .ab_rise(ab_rise), .ba_rise(ba_rise),
  .a_in(a_in), .b_in(b_in), .ab_store(ab_store), .ba_store(ba_store)
);

// File: tb/bidir_xcvr_tb.sv
module bidir_xcvr_tb_top;
  localparam int W      = 18;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ab_oe_n = 1'b0, ab_le = 1'b0, ab_ce_n = 1'b0, ab_cp = 1'b0;
  logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_ce_n = 1'b0, ba_cp = 1'b0;
  logic         tb_a_en = 1'b1, tb_b_en = 1'b0;
  logic [W-1:0] tb_a_val = '0, tb_b_val = '0;
  wire  [W-1:0] a_bus, b_bus;

  int total = 0;
  int bad   = 0;

  assign a_bus = tb_a_en ? tb_a_val : {W{1'bz}};
  assign b_bus = tb_b_en ? tb_b_val : {W{1'bz}};

  always #(PERIOD/2) clk = ~clk;

  bidir_xcvr #(.W(W)) dut_i (
    .clk(clk), .rst(rst),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_ce_n(ab_ce_n), .ab_cp(ab_cp),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_ce_n(ba_ce_n), .ba_cp(ba_cp),
    .a_bus(a_bus), .b_bus(b_bus)
  );

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    check("R8 A-to-B cleared", b_bus, '0);
    tb_a_en = 1'b0; ba_oe_n = 1'b0;
    cyc(1);
    check("R8 B-to-A cleared", a_bus, '0);
    ba_oe_n = 1'b1; tb_a_en = 1'b1;
    cyc(1);
  endtask

  task automatic t_transparent();
    ab_le = 1'b1; ab_ce_n = 1'b1;
    tb_a_val = 18'h2A5A5;
    #1 check("R1 pass", b_bus, 18'h2A5A5);
    ab_cp = 1'b1;
    tb_a_val = 18'h3FFFF;
    #1 check("R9 all ones", b_bus, 18'h3FFFF);
    tb_a_val = 18'h15555;
    #1 check("R9 alternating", b_bus, 18'h15555);
    tb_a_val = 18'h00000;
    #1 check("R9 all zeros", b_bus, 18'h00000);
    ab_cp = 1'b0;
    cyc(4);
    ab_ce_n = 1'b0;
  endtask

  task automatic t_leave_pass();
    ab_le = 1'b1;
    tb_a_val = 18'h1C3E7;
    cyc(2);
    ab_le = 1'b0;
    tb_a_val = 18'h01234;
    cyc(4);
    check("R7 last pass kept", b_bus, 18'h1C3E7);
  endtask

  task automatic t_capture_hold();
    ab_le = 1'b0; ab_ce_n = 1'b0;
    tb_a_val = 18'h0BEEF;
    cyc(1);
    ab_cp = 1'b1;
    cyc(2);
    check("R2 not yet after two edges", b_bus, 18'h01234 ^ 18'h01234 ^ 18'h1C3E7);
    cyc(1);
    check("R2 captured", b_bus, 18'h0BEEF);
    tb_a_val = 18'h3C0F0;
    cyc(4);
    check("R3 clock high steady", b_bus, 18'h0BEEF);
    ab_cp = 1'b0;
    cyc(4);
    check("R3 falling edge", b_bus, 18'h0BEEF);
    ab_cp = 1'b1;
    cyc(4);
    check("R2 second capture", b_bus, 18'h3C0F0);
    ab_cp = 1'b0;
    cyc(3);
  endtask

  task automatic t_ce_block();
    ab_ce_n = 1'b1;
    tb_a_val = 18'h12345;
    cyc(1);
    ab_cp = 1'b1;
    cyc(4);
    check("R4 edge ignored", b_bus, 18'h3C0F0);
    ab_cp = 1'b0;
    cyc(3);
    ab_ce_n = 1'b0;
    cyc(1);
  endtask

  task automatic t_oe();
    ab_oe_n = 1'b1;
    tb_b_en = 1'b1; tb_b_val = 18'h2DB6D;
    cyc(1);
    check("R5 released bus", b_bus, 18'h2DB6D);
    tb_b_en = 1'b0; ab_oe_n = 1'b0;
    cyc(1);
    check("R5 driven again", b_bus, 18'h3C0F0);
  endtask

  task automatic t_reverse();
    ab_oe_n = 1'b1;
    tb_b_en = 1'b1; tb_b_val = 18'h0F0F0;
    tb_a_en = 1'b0; ba_oe_n = 1'b0;
    ba_le = 1'b0; ba_ce_n = 1'b0;
    cyc(1);
    ba_cp = 1'b1;
    cyc(4);
    check("R6 B-to-A capture", a_bus, 18'h0F0F0);
    tb_b_val = 18'h33333;
    cyc(3);
    check("R6 B-to-A hold", a_bus, 18'h0F0F0);
    ba_le = 1'b1;
    #1 check("R6 B-to-A pass", a_bus, 18'h33333);
    ba_le = 1'b0;
    ba_cp = 1'b0;
    cyc(2);
    tb_b_en = 1'b0; ab_oe_n = 1'b0;
    cyc(1);
    check("R6 A-to-B store untouched", b_bus, 18'h3C0F0);
    ba_oe_n = 1'b1; tb_a_en = 1'b1;
    cyc(1);
  endtask

  initial begin
    #(PERIOD * 20000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(1);
    t_reset();
    t_transparent();
    t_leave_pass();
    t_capture_hold();
    t_ce_block();
    t_oe();
    t_reverse();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule